// File: doc/BRIEF.md
# Concurrent Error Detection Fault Classifier

This block runs one exhaustive test of a fault experiment. Two copies of a combinational circuit sit beside it: one with an injected fault, and one fault-free reference. The block drives the same input vector into both copies. It steps through every value of an `IN_W`-bit input once. For each vector it compares the two output buses. It also samples the error flag that the faulty copy's concurrent error detection logic raises. The outputs of both copies must settle within the cycle in which a vector is presented. The block captures them at the end of that cycle and compares them one cycle later.

Over the run the block builds three sticky observations: a wrong result was seen, a wrong result was flagged, and a wrong result went unflagged. When the sweep ends it turns these into one of four verdicts: hidden, detected, undetected or intermittently detected. From the verdict it derives the fault-secure, self-testing and totally-self-checking bits. An error flag raised while the outputs agree does not change the verdict. It is counted as a false alarm instead. The verdict, the property bits and that count are latched together with a one-cycle done pulse and held until the next run finishes.

Top module: `fault_class_engine`

## Requirements
- R1: A `start_i` pulse seen on a rising edge while idle begins a sweep: in the next cycle `busy_o` is 1 and `vec_o` is 0.
- R2: During a sweep `vec_o` increases by one every cycle, from 0 to 2^IN_W-1, so each vector is applied for exactly one cycle.
- R3: `done_o` is high for exactly one cycle. That cycle is 2^IN_W+2 cycles after the edge that accepted start, the cycle after the last vector is evaluated. In that cycle `busy_o` is 0. The result outputs change only with `done_o` and hold their values until the next `done_o`.
- R4: If the two output buses agree on every vector, `class_o` is 2'b00 (hidden).
- R5: If at least one vector has a mismatch and the error flag is 1 on every mismatching vector, `class_o` is 2'b01 (detected).
- R6: If at least one vector has a mismatch and the error flag is 0 on every mismatching vector, `class_o` is 2'b10 (undetected).
- R7: If the error flag is 1 on some mismatching vectors and 0 on others, `class_o` is 2'b11 (intermittently detected).
- R8: `fault_secure_o` is 1 for class 00 or 01. `self_test_o` is 1 for class 01 or 11. `tsc_o` is 1 only for class 01.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored: the vector sequence and the done timing of the current sweep stay unchanged.
- R10: An error flag on a vector whose outputs agree does not affect `class_o`. `false_alarm_o` reports, at done, how many such vectors the sweep had.
- R11: A start pulse in the same cycle as `done_o` is accepted. The new sweep begins with cleared observations and a cleared false-alarm count.
- R12: After reset, `busy_o`, `done_o`, `class_o`, the three property bits, `false_alarm_o` and `vec_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep (ignored while busy) |
| vec_o | output | IN_W | Input vector applied to both circuit copies |
| dut_out_i | input | OUT_W | Outputs of the faulty copy |
| gold_out_i | input | OUT_W | Outputs of the fault-free reference copy |
| ced_err_i | input | 1 | Error flag of the faulty copy's detector |
| busy_o | output | 1 | Sweep or final evaluation in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| class_o | output | 2 | Verdict: 00 hidden, 01 detected, 10 undetected, 11 intermittent |
| fault_secure_o | output | 1 | Fault-secure property bit |
| self_test_o | output | 1 | Self-testing property bit |
| tsc_o | output | 1 | Totally-self-checking property bit |
| false_alarm_o | output | IN_W+1 | Number of flagged vectors whose outputs agreed |

## Verification
The done pulse of one sweep and the acceptance of the next start can fall in the same cycle. If they do, the verdict of the first run must stay on the outputs while its sticky observations and false-alarm count are cleared for the second. The bench raises start exactly in a done cycle after an undetected-fault run. It then switches the fault model to fault-free and checks that the second done reports hidden with zero false alarms, at the expected cycle. Start pulses inside a run, including on the last vector, are also checked: the vector sequence and done timing must not change.

// File: rtl/fce_pkg.sv
package fce_pkg;

    typedef enum logic [1:0] {
        CLS_HIDDEN     = 2'b00,
        CLS_DETECTED   = 2'b01,
        CLS_UNDETECTED = 2'b10,
        CLS_INTERMIT   = 2'b11
    } fce_class_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_EVAL = 2'b10
    } fce_state_e;

    // Verdict from the three sticky observations of a sweep.
    function automatic fce_class_e fce_decode(input logic seen_wrong,
                                              input logic seen_det,
                                              input logic seen_miss);
        fce_class_e c;
        if (!seen_wrong)
            c = CLS_HIDDEN;
        else if (seen_det && !seen_miss)
            c = CLS_DETECTED;
        else if (seen_miss && !seen_det)
            c = CLS_UNDETECTED;
        else
            c = CLS_INTERMIT;
        return c;
    endfunction

endpackage

// File: rtl/fce_sweep_ctrl.sv
module fce_sweep_ctrl
    import fce_pkg::*;
#(
    parameter int IN_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic [IN_W-1:0] vec_o,
    output logic            busy_o,
    output logic            clear_o,
    output logic            smp_en_o,
    output logic            smp_last_o
);

    localparam logic [IN_W-1:0] VEC_LAST = {IN_W{1'b1}};

    typedef struct packed {
        fce_state_e      st;
        logic [IN_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d  = ctrl_q;
        clear_o = 1'b0;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_d.st  = ST_RUN;
                    ctrl_d.cnt = '0;
                    clear_o    = 1'b1;
                end
            end
            ST_RUN: begin
                if (ctrl_q.cnt == VEC_LAST)
                    ctrl_d.st = ST_EVAL;
                else
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
            end
            ST_EVAL: begin
                ctrl_d.st  = ST_IDLE;
                ctrl_d.cnt = '0;
            end
            default: begin
                ctrl_d.st  = ST_IDLE;
                ctrl_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '{st: ST_IDLE, cnt: '0};
        else
            ctrl_q <= ctrl_d;
    end

    assign vec_o      = ctrl_q.cnt;
    assign busy_o     = (ctrl_q.st != ST_IDLE);
    assign smp_en_o   = (ctrl_q.st == ST_RUN);
    assign smp_last_o = (ctrl_q.st == ST_RUN) && (ctrl_q.cnt == VEC_LAST);

    AST_RUN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_IDLE && start_i) |=> (ctrl_q.st == ST_RUN && ctrl_q.cnt == '0)); // R1

    AST_VEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_RUN && ctrl_q.cnt != VEC_LAST)
            |=> (ctrl_q.st == ST_RUN && ctrl_q.cnt == $past(ctrl_q.cnt) + 1'b1)); // R2

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.st == ST_EVAL && start_i) |=> (ctrl_q.st == ST_IDLE)); // R9

endmodule

// File: rtl/fce_sampler.sv
module fce_sampler #(
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en_i,
    input  logic             smp_last_i,
    input  logic [OUT_W-1:0] dut_out_i,
    input  logic [OUT_W-1:0] gold_out_i,
    input  logic             ced_err_i,
    output logic             valid_o,
    output logic             last_o,
    output logic             wrong_o,
    output logic             det_o,
    output logic             miss_o,
    output logic             fa_o
);

    typedef struct packed {
        logic             vld;
        logic             last;
        logic [OUT_W-1:0] dut;
        logic [OUT_W-1:0] gold;
        logic             err;
    } smp_t;

    smp_t smp_d, smp_q;
    logic mism;

    always_comb begin
        smp_d      = smp_q;
        smp_d.vld  = smp_en_i;
        smp_d.last = smp_last_i;
        if (smp_en_i) begin
            smp_d.dut  = dut_out_i;
            smp_d.gold = gold_out_i;
            smp_d.err  = ced_err_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            smp_q <= '0;
        else
            smp_q <= smp_d;
    end

    assign mism    = smp_q.vld && (smp_q.dut != smp_q.gold);
    assign valid_o = smp_q.vld;
    assign last_o  = smp_q.last;
    assign wrong_o = mism;
    assign det_o   = mism && smp_q.err;
    assign miss_o  = mism && !smp_q.err;
    assign fa_o    = smp_q.vld && !mism && smp_q.err;

    AST_SAMPLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en_i |=> valid_o); // R2

    AST_OBS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({det_o, miss_o, fa_o})); // R10

endmodule

// File: rtl/fce_verdict.sv
module fce_verdict
    import fce_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             valid_i,
    input  logic             last_i,
    input  logic             wrong_i,
    input  logic             det_i,
    input  logic             miss_i,
    input  logic             fa_i,
    output logic             done_o,
    output logic [1:0]       class_o,
    output logic             fs_o,
    output logic             st_o,
    output logic             tsc_o,
    output logic [CNT_W-1:0] fa_cnt_o
);

    typedef struct packed {
        logic             seen_wrong;
        logic             seen_det;
        logic             seen_miss;
        logic [CNT_W-1:0] fa_run;
        logic             done;
        fce_class_e       cls;
        logic             fs;
        logic             st;
        logic             tsc;
        logic [CNT_W-1:0] fa_res;
    } vrd_t;

    vrd_t vrd_d, vrd_q;

    logic             nxt_wrong, nxt_det, nxt_miss;
    logic [CNT_W-1:0] nxt_fa;
    fce_class_e       nxt_cls;

    always_comb begin
        nxt_wrong = vrd_q.seen_wrong | wrong_i;
        nxt_det   = vrd_q.seen_det   | det_i;
        nxt_miss  = vrd_q.seen_miss  | miss_i;
        nxt_fa    = vrd_q.fa_run + {{(CNT_W-1){1'b0}}, fa_i};
        nxt_cls   = fce_decode(nxt_wrong, nxt_det, nxt_miss);

        vrd_d      = vrd_q;
        vrd_d.done = 1'b0;
        if (clear_i) begin
            vrd_d.seen_wrong = 1'b0;
            vrd_d.seen_det   = 1'b0;
            vrd_d.seen_miss  = 1'b0;
            vrd_d.fa_run     = '0;
        end else if (valid_i) begin
            vrd_d.seen_wrong = nxt_wrong;
            vrd_d.seen_det   = nxt_det;
            vrd_d.seen_miss  = nxt_miss;
            vrd_d.fa_run     = nxt_fa;
            if (last_i) begin
                vrd_d.done   = 1'b1;
                vrd_d.cls    = nxt_cls;
                vrd_d.fs     = (nxt_cls == CLS_HIDDEN) || (nxt_cls == CLS_DETECTED);
                vrd_d.st     = (nxt_cls == CLS_DETECTED) || (nxt_cls == CLS_INTERMIT);
                vrd_d.tsc    = (nxt_cls == CLS_DETECTED);
                vrd_d.fa_res = nxt_fa;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vrd_q <= '{seen_wrong: 1'b0, seen_det: 1'b0, seen_miss: 1'b0,
                       fa_run: '0, done: 1'b0, cls: CLS_HIDDEN,
                       fs: 1'b0, st: 1'b0, tsc: 1'b0, fa_res: '0};
        else
            vrd_q <= vrd_d;
    end

    assign done_o   = vrd_q.done;
    assign class_o  = vrd_q.cls;
    assign fs_o     = vrd_q.fs;
    assign st_o     = vrd_q.st;
    assign tsc_o    = vrd_q.tsc;
    assign fa_cnt_o = vrd_q.fa_res;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_TSC_IMPLIES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        tsc_o |-> (fs_o && st_o)); // R8

    AST_UNDET_NO_PROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && class_o == CLS_UNDETECTED) |-> (!fs_o && !st_o && !tsc_o)); // R6

    AST_FA_KEEPS_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && fa_i && !clear_i) |=> !vrd_q.seen_wrong || $past(vrd_q.seen_wrong)); // R10

endmodule

// File: rtl/fault_class_engine.sv
module fault_class_engine
    import fce_pkg::*;
#(
    parameter int IN_W  = 4,
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [IN_W-1:0]  vec_o,
    input  logic [OUT_W-1:0] dut_out_i,
    input  logic [OUT_W-1:0] gold_out_i,
    input  logic             ced_err_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       class_o,
    output logic             fault_secure_o,
    output logic             self_test_o,
    output logic             tsc_o,
    output logic [IN_W:0]    false_alarm_o
);

    localparam int CNT_W = IN_W + 1;

    logic clear, smp_en, smp_last;
    logic obs_vld, obs_last, obs_wrong, obs_det, obs_miss, obs_fa;

    fce_sweep_ctrl #(.IN_W(IN_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .vec_o      (vec_o),
        .busy_o     (busy_o),
        .clear_o    (clear),
        .smp_en_o   (smp_en),
        .smp_last_o (smp_last)
    );

    fce_sampler #(.OUT_W(OUT_W)) i_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_en_i   (smp_en),
        .smp_last_i (smp_last),
        .dut_out_i  (dut_out_i),
        .gold_out_i (gold_out_i),
        .ced_err_i  (ced_err_i),
        .valid_o    (obs_vld),
        .last_o     (obs_last),
        .wrong_o    (obs_wrong),
        .det_o      (obs_det),
        .miss_o     (obs_miss),
        .fa_o       (obs_fa)
    );

    fce_verdict #(.CNT_W(CNT_W)) i_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .valid_i  (obs_vld),
        .last_i   (obs_last),
        .wrong_i  (obs_wrong),
        .det_i    (obs_det),
        .miss_i   (obs_miss),
        .fa_i     (obs_fa),
        .done_o   (done_o),
        .class_o  (class_o),
        .fs_o     (fault_secure_o),
        .st_o     (self_test_o),
        .tsc_o    (tsc_o),
        .fa_cnt_o (false_alarm_o)
    );

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R3

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(obs_last)); // R3

endmodule

// File: tb/test_fault_class_engine.sv
`timescale 1ns/1ps
module test_fault_class_engine;

    localparam int IN_W  = 4;
    localparam int OUT_W = 4;
    localparam int NV    = 1 << IN_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [IN_W-1:0]  vec;
    logic [OUT_W-1:0] gold, dut;
    logic             err;
    logic             busy, done, fs, st, tsc;
    logic [1:0]       cls;
    logic [IN_W:0]    fa;

    // Fault model: wmask marks vectors whose faulty output is wrong,
    // emask marks vectors on which the detector raises its flag.
    logic [NV-1:0] wmask = '0;
    logic [NV-1:0] emask = '0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    assign gold = OUT_W'(vec * 3 + 1);
    assign dut  = wmask[vec] ? (gold ^ OUT_W'(1)) : gold;
    assign err  = emask[vec];

    fault_class_engine #(.IN_W(IN_W), .OUT_W(OUT_W)) i_fault_class_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .vec_o          (vec),
        .dut_out_i      (dut),
        .gold_out_i     (gold),
        .ced_err_i      (err),
        .busy_o         (busy),
        .done_o         (done),
        .class_o        (cls),
        .fault_secure_o (fs),
        .self_test_o    (st),
        .tsc_o          (tsc),
        .false_alarm_o  (fa)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One sweep. Returns in the done cycle (at its negedge).
    task automatic do_run(input bit chained, input bit poke, input bit chain_out);
        bit seq_ok = 1'b1;
        if (!chained) begin
            @(negedge clk);
            start = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R1 busy after start", busy, 1);
        chk("R1 first vector", vec, 0);
        for (int k = 1; k <= NV; k++) begin
            if (k > 1) @(negedge clk);
            if (vec != IN_W'(k - 1)) seq_ok = 1'b0;
            if (poke && (k == 5 || k == NV)) start = 1'b1;
            if (poke && k == 6) start = 1'b0;
        end
        chk("R2 vector sequence", seq_ok, 1);
        @(negedge clk);
        start = 1'b0;
        chk("R3 no early done", done, 0);
        chk("R9 busy in final evaluation", busy, 1);
        @(negedge clk);
        chk("R3 done pulse", done, 1);
        chk("R3 idle at done", busy, 0);
        if (chain_out) start = 1'b1;
    endtask

    task automatic chk_result(input string tag, input int ecls, input int efs,
                              input int est, input int etsc, input int efa);
        chk({tag, " class"}, cls, ecls);
        chk({"R8 fault-secure ", tag}, fs, efs);
        chk({"R8 self-test ", tag}, st, est);
        chk({"R8 tsc ", tag}, tsc, etsc);
        chk({"R10 false alarms ", tag}, fa, efa);
    endtask

    task automatic t_reset;
        chk("R12 busy", busy, 0);
        chk("R12 done", done, 0);
        chk("R12 class", cls, 0);
        chk("R12 props", {fs, st, tsc}, 0);
        chk("R12 false alarms", fa, 0);
        chk("R12 vector", vec, 0);
    endtask

    task automatic t_hidden;
        wmask = '0; emask = '0;
        do_run(1'b0, 1'b0, 1'b0);
        chk_result("R4 hidden", 0, 1, 0, 0, 0);
        @(negedge clk);
        chk("R3 done drops", done, 0);
        chk("R3 result held", cls, 0);
    endtask

    task automatic t_detected;
        wmask = '0; emask = '0;
        wmask[3] = 1'b1; wmask[7] = 1'b1;
        emask[3] = 1'b1; emask[7] = 1'b1;
        do_run(1'b0, 1'b0, 1'b0);
        chk_result("R5 detected", 1, 1, 1, 1, 0);
    endtask

    task automatic t_detected_first;
        wmask = '0; emask = '0;
        wmask[0] = 1'b1; emask[0] = 1'b1;
        do_run(1'b0, 1'b0, 1'b0);
        chk_result("R5 detected on vector 0", 1, 1, 1, 1, 0);
    endtask

    task automatic t_undetected_last;
        wmask = '0; emask = '0;
        wmask[NV-1] = 1'b1;
        do_run(1'b0, 1'b0, 1'b0);
        chk_result("R6 undetected on last vector", 2, 0, 0, 0, 0);
    endtask

    task automatic t_intermittent;
        wmask = '0; emask = '0;
        wmask[2] = 1'b1; wmask[9] = 1'b1;
        emask[9] = 1'b1;
        do_run(1'b0, 1'b0, 1'b0);
        chk_result("R7 intermittent", 3, 0, 1, 0, 0);
    endtask

    task automatic t_false_alarm;
        wmask = '0; emask = '0;
        emask[1] = 1'b1; emask[4] = 1'b1; emask[NV-1] = 1'b1;
        do_run(1'b0, 1'b0, 1'b0);
        chk_result("R10 false alarms only", 0, 1, 0, 0, 3);
    endtask

    task automatic t_mixed;
        wmask = '0; emask = '0;
        wmask[6] = 1'b1; emask[6] = 1'b1; emask[10] = 1'b1;
        do_run(1'b0, 1'b0, 1'b0);
        chk_result("R10 detected plus false alarm", 1, 1, 1, 1, 1);
    endtask

    task automatic t_start_ignored;
        wmask = '0; emask = '0;
        wmask[2] = 1'b1; wmask[11] = 1'b1; emask[11] = 1'b1;
        do_run(1'b0, 1'b1, 1'b0);
        chk_result("R9 start during sweep", 3, 0, 1, 0, 0);
    endtask

    task automatic t_back_to_back;
        wmask = '0; emask = '0;
        wmask[5] = 1'b1; emask[8] = 1'b1;
        do_run(1'b0, 1'b0, 1'b1);
        chk_result("R11 first run", 2, 0, 0, 0, 1);
        wmask = '0; emask = '0;
        do_run(1'b1, 1'b0, 1'b0);
        chk_result("R11 second run cleared", 0, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_hidden();
        t_detected();
        t_detected_first();
        t_undetected_last();
        t_intermittent();
        t_false_alarm();
        t_mixed();
        t_start_ignored();
        t_back_to_back();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule